// File: doc/BRIEF.md
# Windowed-Sampling Serial Frame Receiver

This block receives asynchronous serial frames on a single idle-high line. A falling edge on the conditioned line marks the start of a frame. The block then splits every bit period into sixteen equal sample slots of a programmable number of clock cycles each, and takes one sample per slot. Only the samples that fall between a programmable lower and upper slot bound (inclusive) count toward the bit. The bit value is the majority level of those samples. Any sample that disagrees with the others raises a sticky sampling-error flag.

A programmable number of bits is shifted into a 16-bit hold register. Each new bit enters at the top and moves the earlier bits down, so the first bit received ends up lowest among the captured bits. When the last bit has been judged, the word is published and a ready flag is raised. If a word arrives while ready is still set, an overflow flag is raised as well. A single clear strobe drops ready, overflow and sampling error together.

The line passes through a synchronizer before sampling. An optional three-tap majority filter can then suppress single-cycle glitches. The conditioned level is available as a live status bit. Parity is captured as an ordinary bit and is not checked. The lower slot bound must be strictly less than the upper bound.

Top module: `winsamp_rx`

## Requirements
- R1: While the line stays high, no frame starts and ready stays low. A high-to-low transition of the conditioned line while idle starts a frame, and the slot timing is aligned to that transition.
- R2: Each bit lasts 16 sample slots, and each slot lasts `cfg_rate_i` clock cycles. One sample is taken per slot, so changing `cfg_rate_i` scales the bit period accordingly.
- R3: Only samples in slots `cfg_win_lo_i` through `cfg_win_hi_i` (inclusive, slots numbered 0 to 15 from the frame edge) count. A disturbance in any other slot changes neither the bit nor the error flag.
- R4: The bit value is 1 when the high samples in the window are at least as many as the low samples, and 0 otherwise.
- R5: `samp_err_o` is set when, for some bit, neither the high count nor the low count exceeds `cfg_win_hi_i - cfg_win_lo_i`. Once set, it stays set until cleared.
- R6: `cfg_bits_i` = N (1 to 15) captures N bits per frame. The value 0 captures 16 bits.
- R7: Each judged bit enters bit 15 of the shift register and shifts earlier bits toward bit 0. After N bits, bit i of the frame (i = 0 first) sits at position 16-N+i, and the positions below are 0. `hold_o` changes only when a frame completes.
- R8: `ready_o` rises in the cycle after the last bit is judged and stays set until cleared.
- R9: `overflow_o` is set when a frame completes while `ready_o` is still set. The newer word replaces `hold_o`.
- R10: A one-cycle `clr_i` pulse clears `ready_o`, `overflow_o` and `samp_err_o` and leaves `hold_o` unchanged.
- R11: With `cfg_filter_i` = 1, the sampled line is the majority of three consecutive synchronized samples, so isolated single-cycle glitches never reach the window.
- R12: `rx_level_o` shows the current conditioned level of the line.
- R13: After reset, `hold_o` is 0, all flags are 0 and `rx_level_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| cfg_rate_i | input | RATE_W | Clock cycles per sample slot |
| cfg_bits_i | input | BITS_W | Bits per frame, 0 means 16 |
| cfg_win_lo_i | input | SLOT_W | First counted slot |
| cfg_win_hi_i | input | SLOT_W | Last counted slot |
| cfg_filter_i | input | 1 | Enable three-tap majority filter |
| clr_i | input | 1 | Clear strobe for ready, overflow and sampling error |
| hold_o | output | HOLD_W | Last received word |
| ready_o | output | 1 | A received word is waiting |
| overflow_o | output | 1 | A word arrived before the previous one was cleared |
| samp_err_o | output | 1 | Sticky sampling-error flag |
| rx_level_o | output | 1 | Conditioned line level |

## Verification
The assertions check the flag protocol on every cycle. Ready and the error flag are sticky, and overflow rises only on top of ready. The clear strobe wipes all three flags. The hold register changes only at frame completion, and the error flag rises only when a bit is judged. Windowed majority voting, rejection of disturbances outside the window, filter suppression, skewed edges and rate scaling depend on the waveform injected on the line. Only the bench's frames show these, and it compares the captured words and flags against values it computes independently.

// File: rtl/winsamp_rx_pkg.sv
package winsamp_rx_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RECV = 1'b1
   } rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/winsamp_rx_cond.sv
module winsamp_rx_cond
   import winsamp_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_FILTER  = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rx_i,
   input  logic filt_en_i,
   output logic line_o,
   output logic fall_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("winsamp_rx_cond: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   line_d;
   logic                   line_q;
   logic                   prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '1;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
   end

   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (HAS_FILTER) begin : g_filt
         logic [1:0] hist_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) hist_q <= '1;
            else         hist_q <= {hist_q[0], synced};
         end
         assign line_d = filt_en_i ? maj3(synced, hist_q[0], hist_q[1]) : synced;
      end else begin : g_nofilt
         logic unused_filt;
         assign unused_filt = filt_en_i;
         assign line_d      = synced;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         line_q <= 1'b1;
         prev_q <= 1'b1;
      end else begin
         line_q <= line_d;
         prev_q <= line_q;
      end
   end

   assign line_o = line_q;
   assign fall_o = prev_q & ~line_q;

endmodule

// File: rtl/winsamp_rx_timer.sv
module winsamp_rx_timer #(
   parameter int RATE_W = 16,
   parameter int SLOT_W = 4,
   parameter int BITS_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              run_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              tick_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic [BITS_W-1:0] bit_idx_o
);

   logic [RATE_W-1:0] presc_q;
   logic [SLOT_W-1:0] slot_q;
   logic [BITS_W-1:0] bit_q;
   logic [RATE_W:0]   presc_inc;

   assign presc_inc = {1'b0, presc_q} + (RATE_W+1)'(1);
   assign tick_o    = run_i && (presc_inc >= {1'b0, rate_i});

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         presc_q <= '0;
         slot_q  <= '0;
         bit_q   <= '0;
      end else if (start_i) begin
         presc_q <= '0;
         slot_q  <= '0;
         bit_q   <= '0;
      end else if (tick_o) begin
         presc_q <= '0;
         slot_q  <= slot_q + SLOT_W'(1);
         if (slot_q == '1) bit_q <= bit_q + BITS_W'(1);
      end else if (run_i) begin
         presc_q <= presc_q + RATE_W'(1);
      end
   end

   assign slot_o    = slot_q;
   assign bit_idx_o = bit_q;

endmodule

// File: rtl/winsamp_rx_judge.sv
module winsamp_rx_judge #(
   parameter int SLOT_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              tick_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic              line_i,
   input  logic [SLOT_W-1:0] win_lo_i,
   input  logic [SLOT_W-1:0] win_hi_i,
   output logic              done_o,
   output logic              val_o,
   output logic              err_o
);

   localparam int CNT_W = SLOT_W + 1;

   logic [CNT_W-1:0] hi_q, lo_q, hi_n, lo_n, span;
   logic             in_win;
   logic             take;

   assign in_win = (slot_i >= win_lo_i) && (slot_i <= win_hi_i);
   assign take   = tick_i && in_win;
   assign hi_n   = hi_q + CNT_W'(take && line_i);
   assign lo_n   = lo_q + CNT_W'(take && !line_i);
   assign span   = CNT_W'(win_hi_i) - CNT_W'(win_lo_i);

   assign done_o = tick_i && (slot_i == win_hi_i);
   assign val_o  = (hi_n >= lo_n);
   assign err_o  = !((hi_n > span) || (lo_n > span));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (start_i || done_o) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         hi_q <= hi_n;
         lo_q <= lo_n;
      end
   end

endmodule

// File: rtl/winsamp_rx.sv
module winsamp_rx
   import winsamp_rx_pkg::*;
#(
   parameter int RATE_W      = 16,
   parameter int HOLD_W      = 16,
   parameter int BITS_W      = 4,
   parameter int SLOT_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_FILTER  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rx_i,
   input  logic [RATE_W-1:0] cfg_rate_i,
   input  logic [BITS_W-1:0] cfg_bits_i,
   input  logic [SLOT_W-1:0] cfg_win_lo_i,
   input  logic [SLOT_W-1:0] cfg_win_hi_i,
   input  logic              cfg_filter_i,
   input  logic              clr_i,
   output logic [HOLD_W-1:0] hold_o,
   output logic              ready_o,
   output logic              overflow_o,
   output logic              samp_err_o,
   output logic              rx_level_o
);

   localparam int MAX_BITS = 1 << BITS_W;

   generate
      if (HOLD_W < MAX_BITS) begin : g_bad_hold
         $error("winsamp_rx: HOLD_W must hold the largest frame");
      end
      if (SLOT_W < 2) begin : g_bad_slot
         $error("winsamp_rx: SLOT_W must be at least 2");
      end
   endgenerate

   logic              line;
   logic              fall;
   rx_state_e         state_q;
   logic              start;
   logic              run;
   logic              tick;
   logic [SLOT_W-1:0] slot;
   logic [BITS_W-1:0] bit_idx;
   logic              bit_done;
   logic              bit_val;
   logic              bit_err;
   logic [BITS_W-1:0] last_idx;
   logic              frame_done;
   logic [HOLD_W-1:0] shift_q, shift_n, hold_q;
   logic              ready_q, ovf_q, err_q;

   winsamp_rx_cond #(
      .SYNC_STAGES (SYNC_STAGES),
      .HAS_FILTER  (HAS_FILTER)
   ) u_cond (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rx_i      (rx_i),
      .filt_en_i (cfg_filter_i),
      .line_o    (line),
      .fall_o    (fall)
   );

   assign start = (state_q == ST_IDLE) && fall;
   assign run   = (state_q == ST_RECV);

   winsamp_rx_timer #(
      .RATE_W (RATE_W),
      .SLOT_W (SLOT_W),
      .BITS_W (BITS_W)
   ) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start),
      .run_i     (run),
      .rate_i    (cfg_rate_i),
      .tick_o    (tick),
      .slot_o    (slot),
      .bit_idx_o (bit_idx)
   );

   winsamp_rx_judge #(
      .SLOT_W (SLOT_W)
   ) u_judge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start),
      .tick_i   (tick),
      .slot_i   (slot),
      .line_i   (line),
      .win_lo_i (cfg_win_lo_i),
      .win_hi_i (cfg_win_hi_i),
      .done_o   (bit_done),
      .val_o    (bit_val),
      .err_o    (bit_err)
   );

   // a count of zero wraps to the last index of a full-length frame
   assign last_idx   = cfg_bits_i - BITS_W'(1);
   assign frame_done = bit_done && (bit_idx == last_idx);
   assign shift_n    = {bit_val, shift_q[HOLD_W-1:1]};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: if (fall)       state_q <= ST_RECV;
            ST_RECV: if (frame_done) state_q <= ST_IDLE;
            default:                 state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       shift_q <= '0;
      else if (start)    shift_q <= '0;
      else if (bit_done) shift_q <= shift_n;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         hold_q <= '0;
      else if (frame_done) hold_q <= shift_n;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ready_q <= 1'b0;
         ovf_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         ready_q <= frame_done | (ready_q & ~clr_i);
         ovf_q   <= (ovf_q & ~clr_i) | (frame_done & ready_q & ~clr_i);
         err_q   <= (err_q & ~clr_i) | (bit_done & bit_err);
      end
   end

   assign hold_o     = hold_q;
   assign ready_o    = ready_q;
   assign overflow_o = ovf_q;
   assign samp_err_o = err_q;
   assign rx_level_o = line;

endmodule

// File: rtl/winsamp_rx_chk.sv
module winsamp_rx_chk #(
   parameter int HOLD_W = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              clr_i,
   input logic              ready_o,
   input logic              overflow_o,
   input logic              samp_err_o,
   input logic              bit_done,
   input logic              frame_done,
   input logic [HOLD_W-1:0] hold_o
);

   // R8
   ready_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_done |=> ready_o);

   // R8
   ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && !clr_i) |=> ready_o);

   // R9
   ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(overflow_o) |-> $past(ready_o));

   // R9
   ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_done && ready_o && !clr_i) |=> overflow_o);

   // R10
   clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !bit_done) |=> (!ready_o && !overflow_o && !samp_err_o));

   // R7
   hold_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_done |=> $stable(hold_o));

   // R5
   err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (samp_err_o && !clr_i) |=> samp_err_o);

   // R5
   err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(samp_err_o) |-> $past(bit_done));

endmodule

bind winsamp_rx winsamp_rx_chk #(.HOLD_W(HOLD_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .clr_i      (clr_i),
   .ready_o    (ready_o),
   .overflow_o (overflow_o),
   .samp_err_o (samp_err_o),
   .bit_done   (bit_done),
   .frame_done (frame_done),
   .hold_o     (hold_o)
);

// File: tb/tb_winsamp_rx.sv
`timescale 1ns/1ps
module tb_winsamp_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx = 1'b1;
   logic        filt = 1'b0;
   logic        clr = 1'b0;
   logic [15:0] rate = 16'd4;
   logic [3:0]  nbits = 4'd11;
   logic [3:0]  wlo = 4'd4;
   logic [3:0]  whi = 4'd11;
   logic [15:0] hold_o;
   logic        ready_o, overflow_o, samp_err_o, rx_level_o;

   always #4 clk = ~clk;

   winsamp_rx dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .rx_i         (rx),
      .cfg_rate_i   (rate),
      .cfg_bits_i   (nbits),
      .cfg_win_lo_i (wlo),
      .cfg_win_hi_i (whi),
      .cfg_filter_i (filt),
      .clr_i        (clr),
      .hold_o       (hold_o),
      .ready_o      (ready_o),
      .overflow_o   (overflow_o),
      .samp_err_o   (samp_err_o),
      .rx_level_o   (rx_level_o)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   logic [16:0] exp_q[$];
   logic        rdy_q = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] place(input logic [15:0] raw, input int n);
      logic [15:0] m;
      m = (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 32'd1);
      return (raw & m) << (16 - n);
   endfunction

   function automatic logic [15:0] fr11(input logic [7:0] d);
      return {5'b0, 1'b1, ^d, d, 1'b0};
   endfunction

   // scoreboard monitor: one expected item per rising ready
   always @(negedge clk) begin
      if (rst_n && ready_o && !rdy_q) begin
         logic [16:0] e;
         if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected word", 32'(hold_o), 32'd0);
         end else begin
            e = exp_q.pop_front();
            check(hold_o == e[16:1], "R7", "scoreboard hold", 32'(hold_o), 32'(e[16:1]));
            check(samp_err_o == e[0], "R5", "scoreboard error", 32'(samp_err_o), 32'(e[0]));
         end
      end
      rdy_q <= ready_o;
   end

   task automatic send_frame(input logic [15:0] raw, input int n,
                             input int gbit, input int goff, input int glen,
                             input bit comb, input bit skew, input bit push,
                             input logic [15:0] exp_raw, input bit exp_err);
      int bitclk;
      bitclk = 16 * int'(rate);
      if (push) exp_q.push_back({place(exp_raw, n), exp_err});
      for (int i = 0; i < n; i++) begin
         int   dur;
         logic lvl;
         dur = bitclk + (skew ? ((i % 2 == 1) ? 6 : -6) : 0);
         lvl = raw[i];
         for (int k = 0; k < dur; k++) begin
            logic v;
            v = lvl;
            if (i == gbit) begin
               if (comb) begin
                  if (k >= 6 && k < dur - 6 && k % 3 == 0) v = ~lvl;
               end else if (k >= goff && k < goff + glen) begin
                  v = ~lvl;
               end
            end
            @(negedge clk);
            rx = v;
            if (i == 0 && k == dur / 2 + 4 && gbit != 0)
               check(rx_level_o == 1'b0, "R12", "level in start bit", 32'(rx_level_o), 32'd0);
         end
      end
      @(negedge clk);
      rx = 1'b1;
      repeat (3 * bitclk) @(negedge clk);
   endtask

   task automatic post(input string req, input logic [15:0] exp_hold, input bit exp_err);
      check(ready_o == 1'b1, req, "ready", 32'(ready_o), 32'd1);
      check(hold_o == exp_hold, req, "hold", 32'(hold_o), 32'(exp_hold));
      check(samp_err_o == exp_err, req, "sampling error", 32'(samp_err_o), 32'(exp_err));
   endtask

   task automatic do_clear();
      logic [15:0] h;
      h = hold_o;
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
      check({ready_o, overflow_o, samp_err_o} == 3'b000, "R10", "flags after clear",
            32'({ready_o, overflow_o, samp_err_o}), 32'd0);
      check(hold_o == h, "R10", "hold kept by clear", 32'(hold_o), 32'(h));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] f;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R13 reset state
      check(hold_o == 16'h0, "R13", "hold", 32'(hold_o), 32'd0);
      check({ready_o, overflow_o, samp_err_o} == 3'b000, "R13", "flags",
            32'({ready_o, overflow_o, samp_err_o}), 32'd0);
      check(rx_level_o == 1'b1, "R13", "level", 32'(rx_level_o), 32'd1);

      // R1 idle line starts nothing
      repeat (300) @(negedge clk);
      check(ready_o == 1'b0, "R1", "ready on idle line", 32'(ready_o), 32'd0);
      check(rx_level_o == 1'b1, "R12", "idle level", 32'(rx_level_o), 32'd1);

      // clean 11-bit frame
      f = fr11(8'hA5);
      send_frame(f, 11, -1, 0, 0, 1'b0, 1'b0, 1'b1, f, 1'b0);
      post("R6", place(f, 11), 1'b0);
      do_clear();

      // skewed edges
      f = fr11(8'hC3);
      send_frame(f, 11, -1, 0, 0, 1'b0, 1'b1, 1'b1, f, 1'b0);
      post("R1", place(f, 11), 1'b0);
      do_clear();

      // halved slot length
      rate = 16'd2;
      f = fr11(8'h5A);
      send_frame(f, 11, -1, 0, 0, 1'b0, 1'b0, 1'b1, f, 1'b0);
      post("R2", place(f, 11), 1'b0);
      do_clear();
      rate = 16'd4;

      // one dissenting sample inside the window
      f = fr11(8'h3C);
      send_frame(f, 11, 3, 28, 4, 1'b0, 1'b0, 1'b1, f, 1'b1);
      post("R5", place(f, 11), 1'b1);
      do_clear();

      // five of eight samples inverted: bit flips
      f = fr11(8'h0F);
      send_frame(f, 11, 5, 20, 20, 1'b0, 1'b0, 1'b1, f ^ 16'h0020, 1'b1);
      post("R4", place(f ^ 16'h0020, 11), 1'b1);
      do_clear();

      // three of eight inverted: majority keeps the bit
      f = fr11(8'h81);
      send_frame(f, 11, 4, 20, 12, 1'b0, 1'b0, 1'b1, f, 1'b1);
      post("R4", place(f, 11), 1'b1);
      do_clear();

      // narrow late window: early disturbance ignored, late one counted
      wlo = 4'd12;
      whi = 4'd14;
      f = fr11(8'h66);
      send_frame(f, 11, 2, 8, 8, 1'b0, 1'b0, 1'b1, f, 1'b0);
      post("R3", place(f, 11), 1'b0);
      do_clear();
      send_frame(f, 11, 2, 52, 4, 1'b0, 1'b0, 1'b1, f, 1'b1);
      post("R3", place(f, 11), 1'b1);
      do_clear();
      wlo = 4'd4;
      whi = 4'd11;

      // single-cycle glitch train without and with filter
      f = fr11(8'h55);
      send_frame(f, 11, 6, 0, 0, 1'b1, 1'b0, 1'b1, f, 1'b1);
      post("R11", place(f, 11), 1'b1);
      do_clear();
      filt = 1'b1;
      send_frame(f, 11, 6, 0, 0, 1'b1, 1'b0, 1'b1, f, 1'b0);
      post("R11", place(f, 11), 1'b0);
      do_clear();
      filt = 1'b0;

      // full 16-bit frame selected by zero
      nbits = 4'd0;
      f = 16'hB5A4;
      send_frame(f, 16, -1, 0, 0, 1'b0, 1'b0, 1'b1, f, 1'b0);
      post("R6", f, 1'b0);
      do_clear();

      // short frame: low positions stay zero
      nbits = 4'd8;
      f = 16'h0096;
      send_frame(f, 8, -1, 0, 0, 1'b0, 1'b0, 1'b1, f, 1'b0);
      post("R7", 16'h9600, 1'b0);
      do_clear();
      nbits = 4'd11;

      // overflow: second word without clearing
      f = fr11(8'h12);
      send_frame(f, 11, -1, 0, 0, 1'b0, 1'b0, 1'b1, f, 1'b0);
      check(overflow_o == 1'b0, "R9", "overflow after first word", 32'(overflow_o), 32'd0);
      f = fr11(8'hED);
      send_frame(f, 11, -1, 0, 0, 1'b0, 1'b0, 1'b0, f, 1'b0);
      check(overflow_o == 1'b1, "R9", "overflow after second word", 32'(overflow_o), 32'd1);
      check(ready_o == 1'b1, "R8", "ready kept", 32'(ready_o), 32'd1);
      check(hold_o == place(f, 11), "R9", "newer word kept", 32'(hold_o), 32'(place(f, 11)));
      do_clear();

      check(exp_q.size() == 0, "R8", "words not delivered", 32'(exp_q.size()), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule